// File: doc/BRIEF.md
# Synchronous Queue with Tail Rewrite

This block is a single-clock first-in first-out queue. It adds one command to the usual push and pop: a tail rewrite. When the producer raises `wr_en` together with `wr_replace`, the block stores `wr_data` over the entry it wrote most recently. Occupancy does not change. A producer can use this to correct or merge the last item it queued, as long as the consumer has not taken that item yet.

The output side is fixed at compile time by the `SHOW_AHEAD` parameter. With `SHOW_AHEAD = 1`, the head entry is always visible on `rd_data` while the queue holds data. With `SHOW_AHEAD = 0`, `rd_data` is a register. It loads the head entry only on a clock edge where a read is accepted, and holds its value at all other times. The depth does not have to be a power of two. Both pointers wrap explicitly at `DEPTH`.

Top module: `repl_fifo`

## Requirements
- R1: `can_read` is high exactly when `fill` is nonzero, and `can_write` is high exactly when `fill` is below `DEPTH`.
- R2: A push (`wr_en`=1, `wr_replace`=0) appends `wr_data` at the tail only when `can_write` is high. A push while full leaves the stored contents and `fill` untouched.
- R3: On each clock, `fill` rises by one for an accepted push and falls by one for an accepted read (`can_read` and `rd_en`). When both happen in the same cycle, `fill` stays the same. `fill` never exceeds `DEPTH`.
- R4: A rewrite (`wr_en`=1, `wr_replace`=1) stores `wr_data` into the entry written most recently, counted after any read in the same cycle. It leaves `fill` unchanged. Rewriting an empty queue, or the entry being read in that cycle, is not defined.
- R5: With `SHOW_AHEAD`=1, `rd_data` equals the head entry whenever `can_read` is high. A push into an empty queue, or a rewrite of a lone entry, shows that cycle's `wr_data` on `rd_data` one cycle later.
- R6: With `SHOW_AHEAD`=0, `rd_data` takes the head entry on an edge where `can_read` and `rd_en` are both high, and holds in every other cycle.
- R7: While `rst` is high and after it is released, `fill` is 0, `can_read` is low and `can_write` is high. The registered-mode `rd_data` clears to 0.
- R8: A read request on an empty queue is ignored. `fill` stays 0, and the next push is the next item read out.
- R9: With a depth that is not a power of two (default 5), order is kept across many pointer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | WIDTH | Data to push or to rewrite |
| wr_en | input | 1 | Write command |
| wr_replace | input | 1 | With `wr_en`, rewrite the tail instead of appending |
| can_write | output | 1 | Queue has a free slot |
| rd_data | output | WIDTH | Head entry (show-ahead) or last read value (registered) |
| rd_en | input | 1 | Read request |
| can_read | output | 1 | Queue holds at least one entry |
| fill | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
Two instances run side by side from the same stimulus, one per output mode, so the fall-through and registered paths are separated on every cycle. The directed parts cover the following cases:
- reading an empty queue, which tells an ignored read apart from a pointer slip;
- pushing against a full queue, which shows whether an overflow write is dropped or corrupts data;
- rewriting with and without a concurrent read, which shows whether the tail index is taken before or after the pop;
- rewriting a lone entry, which exposes a stale show-ahead output.

A long random mix of pushes, reads and legal rewrites then drives both pointers through many wraps at depth 5. This separates correct wrap-at-DEPTH logic from plain binary rollover.

// File: rtl/repl_fifo_pkg.sv
package repl_fifo_pkg;

    typedef struct packed {
        logic push;     // accepted append
        logic pop;      // accepted read
        logic rewrite;  // tail overwrite
    } fifo_ops_t;

    function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
        return (idx + 1 == depth) ? 0 : idx + 1;
    endfunction

    function automatic int unsigned wrap_dec(input int unsigned idx, input int unsigned depth);
        return (idx == 0) ? depth - 1 : idx - 1;
    endfunction

endpackage

// File: rtl/fifo_ptrs.sv
module fifo_ptrs
    import repl_fifo_pkg::*;
#(
    parameter int DEPTH = 5,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_ops_t     ops,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] last_idx,
    output logic [AW-1:0] rd_idx,
    output logic [CW-1:0] count
);

    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (ops.push)
                wr_q <= AW'(wrap_inc(int'(wr_q), DEPTH));
            if (ops.pop)
                rd_q <= AW'(wrap_inc(int'(rd_q), DEPTH));
            case ({ops.push, ops.pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign wr_idx   = wr_q;
    assign rd_idx   = rd_q;
    assign last_idx = AW'(wrap_dec(int'(wr_q), DEPTH));
    assign count    = cnt_q;

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_go,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_word
);

    logic [WIDTH-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go)
            slots[wr_addr] <= wr_word;
    end

    assign rd_word = slots[rd_addr];

endmodule

// File: rtl/fifo_out_reg.sv
module fifo_out_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] head,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= head;
    end

endmodule

// File: rtl/repl_fifo.sv
module repl_fifo
    import repl_fifo_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int DEPTH      = 5,
    parameter bit SHOW_AHEAD = 1'b1,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en,
    input  logic             wr_replace,
    output logic             can_write,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_en,
    output logic             can_read,
    output logic [CW-1:0]    fill
);

    fifo_ops_t     ops;
    logic [AW-1:0] wr_idx, last_idx, rd_idx, mem_waddr;
    logic [CW-1:0] count;
    logic [WIDTH-1:0] head;

    assign can_read  = (count != '0);
    assign can_write = (count < CW'(DEPTH));
    assign fill      = count;

    always_comb begin
        ops.push    = wr_en & ~wr_replace & can_write;
        ops.pop     = rd_en & can_read;
        ops.rewrite = wr_en & wr_replace;
    end

    assign mem_waddr = ops.rewrite ? last_idx : wr_idx;

    fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .ops      (ops),
        .wr_idx   (wr_idx),
        .last_idx (last_idx),
        .rd_idx   (rd_idx),
        .count    (count)
    );

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_go   (ops.push | ops.rewrite),
        .wr_addr (mem_waddr),
        .wr_word (wr_data),
        .rd_addr (rd_idx),
        .rd_word (head)
    );

    generate
        if (SHOW_AHEAD) begin : g_ahead
            assign rd_data = head;
        end else begin : g_registered
            fifo_out_reg #(.WIDTH(WIDTH)) u_out (
                .clk  (clk),
                .rst  (rst),
                .load (ops.pop),
                .head (head),
                .q    (rd_data)
            );
        end
    endgenerate

endmodule

// File: rtl/repl_fifo_chk.sv
module repl_fifo_chk #(
    parameter int WIDTH      = 8,
    parameter int DEPTH      = 5,
    parameter bit SHOW_AHEAD = 1'b1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] wr_data,
    input logic             wr_en,
    input logic             wr_replace,
    input logic             can_write,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_en,
    input logic             can_read,
    input logic [CW-1:0]    fill
);

    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    p_flags_r1: assert property (@(posedge clk) disable iff (rst)
        (can_read == (fill != '0)) && (can_write == (fill < CW'(DEPTH))));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(wr_en && !wr_replace && !can_write && !rd_en) |-> $stable(fill));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> int'(fill) == int'($past(fill))
            + ($past(wr_en && !wr_replace && can_write) ? 1 : 0)
            - ($past(can_read && rd_en) ? 1 : 0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    p_rewrite_keep_r4: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(wr_en && wr_replace && !rd_en) |-> $stable(fill));

    p_reset_state_r7: assert property (@(posedge clk) disable iff (rst)
        !past_ok |-> (fill == '0) && !can_read && can_write);

    p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(!can_read && rd_en && !wr_en) |-> fill == '0);

    generate
        if (SHOW_AHEAD) begin : g_ahead_chk
            p_fill_shows_r5: assert property (@(posedge clk) disable iff (rst)
                past_ok && $past(wr_en && !wr_replace && fill == '0) |-> rd_data == $past(wr_data));
        end else begin : g_reg_chk
            p_hold_r6: assert property (@(posedge clk) disable iff (rst)
                past_ok && !$past(can_read && rd_en) |-> $stable(rd_data));
        end
    endgenerate

endmodule

bind repl_fifo repl_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SHOW_AHEAD(SHOW_AHEAD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_data    (wr_data),
    .wr_en      (wr_en),
    .wr_replace (wr_replace),
    .can_write  (can_write),
    .rd_data    (rd_data),
    .rd_en      (rd_en),
    .can_read   (can_read),
    .fill       (fill)
);

// File: tb/sim_repl_fifo.sv
`timescale 1ns/1ps
module sim_repl_fifo;

    localparam int W  = 8;
    localparam int D  = 5;
    localparam int CW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic wr_en = 1'b0, wr_replace = 1'b0, rd_en = 1'b0;

    logic can_write0, can_read0, can_write1, can_read1;
    logic [W-1:0] rd_data0, rd_data1;
    logic [CW-1:0] fill0, fill1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int unsigned exp_q[$];
    int unsigned reg_exp = 0;

    always #2.5 clk = ~clk;

    repl_fifo #(.WIDTH(W), .DEPTH(D), .SHOW_AHEAD(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en), .wr_replace(wr_replace),
        .can_write(can_write0), .rd_data(rd_data0), .rd_en(rd_en), .can_read(can_read0), .fill(fill0));

    repl_fifo #(.WIDTH(W), .DEPTH(D), .SHOW_AHEAD(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_en(wr_en), .wr_replace(wr_replace),
        .can_write(can_write1), .rd_data(rd_data1), .rd_en(rd_en), .can_read(can_read1), .fill(fill1));

    task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor side: compare both instances against the scoreboard queue
    task automatic verify(input string tag);
        int unsigned sz = exp_q.size();
        chk(tag, "fill0", fill0, sz);
        chk(tag, "fill1", fill1, sz);
        chk({tag, "/R1"}, "can_read", {can_read0, can_read1}, (sz > 0) ? 2'b11 : 2'b00);
        chk({tag, "/R1"}, "can_write", {can_write0, can_write1}, (sz < D) ? 2'b11 : 2'b00);
        if (sz > 0) chk({tag, "/R5"}, "ahead rd_data", rd_data0, exp_q[0]);
        chk({tag, "/R6"}, "registered rd_data", rd_data1, reg_exp);
    endtask

    // driver: apply one cycle of stimulus, update the scoreboard, then check
    task automatic step(input bit w, input bit rp, input int unsigned d, input bit r, input string tag);
        int unsigned sz;
        wr_en = w; wr_replace = rp; wr_data = W'(d); rd_en = r;
        @(posedge clk);
        @(negedge clk);
        sz = exp_q.size();
        if (r && sz > 0) reg_exp = exp_q.pop_front();
        if (w && rp) begin
            if (exp_q.size() > 0) exp_q[exp_q.size() - 1] = d;
        end else if (w && sz < D) begin
            exp_q.push_back(d);
        end
        wr_en = 1'b0; wr_replace = 1'b0; rd_en = 1'b0;
        verify(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: reset state
        chk("R7", "fill", fill0, 0);
        chk("R7", "can_read", can_read0, 0);
        chk("R7", "can_write", can_write0, 1);
        chk("R7", "registered rd_data", rd_data1, 0);

        // R8: reads on an empty queue are ignored
        step(0, 0, 0, 1, "R8");
        step(0, 0, 0, 1, "R8");
        step(1, 0, 8'h21, 0, "R8 R5 first push");
        step(0, 0, 0, 1, "R8 R6 read");
        step(0, 0, 0, 0, "R6 hold");

        // R2: fill to full, then push against full
        for (int i = 0; i < D; i++) step(1, 0, 8'h30 + i, 0, "R2 fill");
        step(1, 0, 8'hEE, 0, "R2 push when full");
        step(1, 0, 8'hEF, 0, "R2 push when full");
        // R3: read and push together while full: push refused (can_write low)
        step(1, 0, 8'h40, 1, "R3 full rd+wr");
        // R3: read and push together when not full
        step(1, 0, 8'h41, 1, "R3 rd+wr");
        // R6: drain with idle gaps
        for (int i = 0; i < D; i++) begin
            step(0, 0, 0, 1, "R6 drain");
            step(0, 0, 0, 0, "R6 hold");
        end

        // R4: rewrite tail without a read
        step(1, 0, 8'h50, 0, "R4 setup");
        step(1, 0, 8'h51, 0, "R4 setup");
        step(1, 0, 8'h52, 0, "R4 setup");
        step(1, 1, 8'h5A, 0, "R4 rewrite");
        step(1, 1, 8'h5B, 0, "R4 rewrite again");
        // R4: rewrite while reading (tail counted after the pop)
        step(1, 1, 8'h5C, 1, "R4 rewrite+read");
        step(0, 0, 0, 1, "R4 drain");
        step(0, 0, 0, 1, "R4 drain");
        // R5: lone entry rewrite updates show-ahead output
        step(1, 0, 8'h60, 0, "R5 lone");
        step(1, 1, 8'h61, 0, "R5 R4 lone rewrite");
        step(0, 0, 0, 1, "R5 drain");

        // R9: random traffic through many wraps at depth 5
        for (int i = 0; i < 600; i++) begin
            bit r, w, rp;
            int unsigned after;
            r = ($urandom % 2) == 0;
            w = ($urandom % 4) != 0;
            after = exp_q.size() - ((r && exp_q.size() > 0) ? 1 : 0);
            rp = w && (($urandom % 5) == 0) && (after >= 1);
            step(w, rp, $urandom % 256, r, "R9 R3 random");
        end
        while (exp_q.size() > 0) step(0, 0, 0, 1, "R9 final drain");
        step(0, 0, 0, 1, "R8 empty after drain");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule